// File: doc/BRIEF.md
# Fractional-Rate Clock-Enable Generator

This block turns a fast system clock into a stream of one-cycle enable pulses whose average rate is a rational fraction N/M of the clock rate, with N < M. With the default N = 83 and M = 125, a 50 MHz clock yields an average enable rate of 33.2 MHz. The registers that consume the enable stay on the fast clock and update only in cycles where the enable is high. No derived clock and no second clock domain is created.

Two placements of the pulses are offered. In the even mode a modulo accumulator spaces the enables as uniformly as the ratio allows. This is the mode to prefer. In the grouped mode a position counter places all N enables at the head of each M-cycle window. A run input pauses the generator without losing its place. A mode request is honoured only at a window boundary, so every window holds exactly N enables.

Top module: `frac_enable_gen`

## Requirements
- R1: While `rst` is high, `en_o` is low. The first run cycle after reset is window position 0, and the even mode (`burst_sel` = 0) is the held mode.
- R2: In the even mode (`burst_sel` = 0), the accumulator adds N on each run cycle. `en_o` is high in exactly those run cycles where the sum reaches or passes M, and in those cycles M is subtracted. At window position p this means that `en_o` equals floor((p+1)N/M) - floor(pN/M).
- R3: After every update the accumulator holds a value from 0 to M-1.
- R4: In the grouped mode (`burst_sel` = 1), `en_o` is high on window positions 0 to N-1 and low on positions N to M-1.
- R5: Every aligned window of M run cycles contains exactly N enables, in either mode.
- R6: In the even mode with N = 83 and M = 125, consecutive enables are never more than 2 run cycles apart, and a gap of 2 does occur.
- R7: While `run` is low, `en_o` is low and the window position and accumulator hold their values. The sequence resumes where it stopped.
- R8: `burst_sel` is sampled only in cycles at window position 0. A change in the middle of a window has no effect until the next window begins.
- R9: The window position counts run cycles from 0 to M-1 and then wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| burst_sel | input | 1 | Placement request: 0 = even spacing, 1 = grouped at window head |
| run | input | 1 | Advances the generator when high; holds it when low |
| en_o | output | 1 | One-cycle clock-enable pulse |

## Verification
At a window boundary, two decisions fall in the same cycle: taking a new placement mode and producing that cycle's enable. The enable must already follow the newly chosen mode. The bench provokes this by changing `burst_sel` in the middle of a window, and also by holding a changed request through a pause that ends at a boundary. Each cycle is judged against a position-indexed model: the mode is latched only at position 0, and the output and the per-window count must match it. A reset asserted in the middle of a window, while `run` is high, checks that clearing takes priority over the enable decision.

// File: rtl/frac_enable_gen.sv
module frac_enable_gen #(
  parameter int N = 83,
  parameter int M = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic burst_sel,
  input  logic run,
  output logic en_o
);
  localparam int AW = $clog2(M + N);
  localparam int CW = (M > 1) ? $clog2(M) : 1;

  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_sum;
  logic [CW-1:0] cnt_q;
  logic          mode_q;
  logic          at_edge;
  logic          cnt_last;
  logic          carry;
  logic          mode_eff;

  assign acc_sum  = acc_q + AW'(N);
  assign carry    = acc_sum >= AW'(M);
  assign at_edge  = cnt_q == '0;
  assign cnt_last = cnt_q == CW'(M - 1);
  assign mode_eff = at_edge ? burst_sel : mode_q;
  assign en_o     = run & ~rst & (mode_eff ? (cnt_q < CW'(N)) : carry);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= mode_eff;
      if (run) begin
        acc_q <= carry ? acc_sum - AW'(M) : acc_sum;
        cnt_q <= cnt_last ? '0 : cnt_q + CW'(1);
      end
    end
  end
endmodule

module frac_enable_chk #(
  parameter int N  = 83,
  parameter int M  = 125,
  parameter int AW = 8,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          en_o,
  input logic [AW-1:0] acc,
  input logic [CW-1:0] cnt,
  input logic          mode
);
  localparam int WW = $clog2(M + 1);
  logic [WW-1:0] win_q;

  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else if (run) win_q <= (cnt == CW'(M - 1)) ? '0 : win_q + WW'(en_o);
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |-> !en_o); // R1
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (acc == '0 && cnt == '0 && !mode)); // R1
  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (rst) acc < AW'(M)); // R3
  AST_WINDOW_COUNT: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == CW'(M - 1)) |-> (int'(win_q) + int'(en_o) == N)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !run |-> !en_o); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(acc) && $stable(cnt))); // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> $stable(mode)); // R8
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == CW'(M - 1)) |=> (cnt == '0)); // R9
endmodule

bind frac_enable_gen frac_enable_chk #(.N(N), .M(M), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .en_o(en_o),
  .acc(acc_q), .cnt(cnt_q), .mode(mode_q)
);

// File: tb/tb_frac_enable_gen.sv
`timescale 1ns/1ps
module tb_frac_enable_gen;
  localparam int N = 83;
  localparam int M = 125;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic burst_sel = 1'b0;
  logic run = 1'b0;
  logic en_o;

  frac_enable_gen #(.N(N), .M(M)) dut (
    .clk(clk), .rst(rst), .burst_sel(burst_sel), .run(run), .en_o(en_o)
  );

  always #2.5 clk = ~clk;

  // segment: {burst_sel, run, cycles[15:0]}
  localparam int NSEG = 12;
  localparam logic [17:0] SEGS [NSEG] = '{
    {1'b0, 1'b1, 16'd250},
    {1'b1, 1'b1, 16'd250},
    {1'b0, 1'b1, 16'd60},
    {1'b1, 1'b1, 16'd65},
    {1'b1, 1'b1, 16'd125},
    {1'b0, 1'b1, 16'd40},
    {1'b1, 1'b0, 16'd17},
    {1'b0, 1'b1, 16'd85},
    {1'b1, 1'b1, 16'd30},
    {1'b1, 1'b0, 16'd10},
    {1'b0, 1'b1, 16'd95},
    {1'b0, 1'b1, 16'd375}
  };

  int checks = 0;
  int failures = 0;
  int pos = 0;
  logic lat = 1'b0;
  int win_en = 0;
  int since_en = -1;
  int max_gap = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d pos=%0d t=%0t", req, act, exp, pos, $time);
    end
  endtask

  task automatic step(input logic bs, input logic rn, input logic rs);
    logic eff;
    logic exp;
    @(negedge clk);
    burst_sel = bs; run = rn; rst = rs;
    #1;
    if (rs) begin
      chk("R1 enable low in reset", int'(en_o), 0);
      pos = 0; lat = 1'b0; win_en = 0; since_en = -1;
      return;
    end
    eff = (pos == 0) ? bs : lat;
    if (!rn) exp = 1'b0;
    else if (eff) exp = (pos < N);
    else exp = (((pos + 1) * N) / M - (pos * N) / M) != 0;
    if (!rn) chk("R7 enable low while paused", int'(en_o), 0);
    else if (eff) chk("R4/R8 grouped placement", int'(en_o), int'(exp));
    else chk("R2/R8 even placement", int'(en_o), int'(exp));
    lat = eff;
    if (rn) begin
      if (eff) since_en = -1;
      else if (exp) begin
        if (since_en >= 0) begin
          if (since_en + 1 > max_gap) max_gap = since_en + 1;
          chk("R6 even gap at most 2", int'(since_en + 1 <= 2), 1);
        end
        since_en = 0;
      end else if (since_en >= 0) since_en++;
      if (en_o) win_en++;
      if (pos == M - 1) begin
        chk("R5 enables per window", win_en, N);
        win_en = 0;
        pos = 0;
      end else pos++;
    end
  endtask

  initial begin
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1);
    for (int s = 0; s < NSEG; s++)
      for (int c = 0; c < int'(SEGS[s][15:0]); c++)
        step(SEGS[s][17], SEGS[s][16], 1'b0);
    // R1: reset mid-window while running and requesting grouped mode
    for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1);
    // R1, R9: restart at position 0; grouped mode taken at the first boundary
    for (int i = 0; i < 2 * M; i++) step(1'b1, 1'b1, 1'b0);
    // R8: pause across a boundary with the request changed during the pause
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 2 * M; i++) step(1'b0, 1'b1, 1'b0);
    chk("R6 largest even gap is 2", max_gap, 2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule